// File: doc/BRIEF.md
# Extended Configuration Switch Executor

This block carries out the card-side handling of a "switch" request against a byte-addressed extended configuration space of 256 indices. A 32-bit argument arrives with a one-cycle valid strobe. The block splits the argument into its fields, checks that the request is legal, and either applies it or rejects it. A legal byte request rewrites, sets bits in, or clears bits in one writable byte. A legal command-set request changes the active command set.

A rejected request raises a switch error flag and changes no storage. An accepted request clears that flag and holds a busy output for a fixed number of cycles, during which further requests are dropped. Only the five writable bytes are kept in flip-flops. Read-only bytes are supplied by a constant image input. A combinational byte read port returns any index.

Top module: `xcfg_switch_unit`

## Requirements
- R1: The argument is decoded as [31:26] must-be-zero, [25:24] access mode, [23:16] byte index, [15:8] value, [7:3] must-be-zero, [2:0] command set. Mode 3 replaces the addressed writable byte with the value.
- R2: Mode 1 ORs the value into the addressed writable byte.
- R3: Mode 2 clears, in the addressed writable byte, every bit that is 1 in the value.
- R4: Mode 0 loads `cmd_set` from argument bits [2:0] when that field is 3'b001, 3'b010 or 3'b100. Any other field value is rejected with switch error. `cmd_set` resets to 3'b001 and always holds exactly one set bit.
- R5: The writable indices are 156, 175, 179, 183 and 185. All of them read 0 after reset.
- R6: Read-only indices return a byte of `ro_image`, and byte k (bits [8k+7:8k]) belongs to the k-th entry of this ascending list: 160, 166, 192, 194, 196, 212, 213, 214, 215, 217, 221, 222, 223, 224, 229, 230, 231, 232. Every other non-writable index reads 0. A byte request in modes 1 to 3 aimed at any non-writable index is rejected, and no storage changes.
- R7: A request with any must-be-zero bit set is rejected in every mode, and no storage changes.
- R8: A byte request to index 183 is rejected when its result would not be one of 0, 1, 2, 5 or 6.
- R9: A request is taken on a rising clock edge where `arg_valid` is 1 and `busy` is 0. From the next cycle, an accepted request gives `switch_err` 0 and `busy` 1 for exactly BUSY_CYCLES cycles. A rejected request gives `switch_err` 1 and leaves `busy` at 0.
- R10: A request presented while `busy` is 1 is ignored: no byte, `cmd_set` or `switch_err` changes.
- R11: `rd_data` follows `rd_idx` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arg_valid | input | 1 | Request strobe |
| arg | input | 32 | Switch argument |
| ro_image | input | 144 | Constant read-only byte image, 18 bytes |
| rd_idx | input | 8 | Read port byte index |
| rd_data | output | 8 | Read port byte |
| busy | output | 1 | Update in progress |
| switch_err | output | 1 | Last taken request was rejected |
| cmd_set | output | 3 | Active command set, one-hot |

## Verification
A request is taken at a rising edge. The updated byte, `cmd_set`, `switch_err` and the rise of `busy` all become visible in the cycle after that edge, so the bench samples all of them at the following falling edge. Busy is then sampled again BUSY_CYCLES-1 falling edges later, where it must still be 1, and once more one edge after that, where it must be 0. Reads through `rd_idx` need no clock edge, so the bench drives the index and samples `rd_data` a short delay later within the same low clock phase.

// File: rtl/xcfg_pkg.sv
package xcfg_pkg;

    localparam int ARG_W  = 32;
    localparam int IDX_W  = 8;
    localparam int BYTE_W = 8;
    localparam int CSET_W = 3;
    localparam int N_WR   = 5;
    localparam int N_RO   = 18;
    localparam int SLOT_W = $clog2(N_WR);
    localparam int RO_W   = N_RO * BYTE_W;

    localparam logic [IDX_W-1:0]  BW_IDX      = 8'd183;
    localparam logic [CSET_W-1:0] CSET_NORMAL = 3'b001;

    typedef enum logic [1:0] {
        MODE_CMDSET = 2'd0,
        MODE_SETB   = 2'd1,
        MODE_CLRB   = 2'd2,
        MODE_WRITE  = 2'd3
    } acc_mode_e;

    typedef struct packed {
        logic [5:0]        mbz_hi;
        acc_mode_e         mode;
        logic [IDX_W-1:0]  index;
        logic [BYTE_W-1:0] value;
        logic [4:0]        mbz_lo;
        logic [CSET_W-1:0] cset;
    } sw_arg_t;

    typedef struct packed {
        logic              we;
        logic [SLOT_W-1:0] slot;
        logic [BYTE_W-1:0] data;
    } wr_cmd_t;

    function automatic logic [IDX_W-1:0] wr_index(input int slot);
        case (slot)
            0:       return 8'd156;
            1:       return 8'd175;
            2:       return 8'd179;
            3:       return 8'd183;
            default: return 8'd185;
        endcase
    endfunction

    function automatic logic [IDX_W-1:0] ro_index(input int k);
        case (k)
            0:  return 8'd160;
            1:  return 8'd166;
            2:  return 8'd192;
            3:  return 8'd194;
            4:  return 8'd196;
            5:  return 8'd212;
            6:  return 8'd213;
            7:  return 8'd214;
            8:  return 8'd215;
            9:  return 8'd217;
            10: return 8'd221;
            11: return 8'd222;
            12: return 8'd223;
            13: return 8'd224;
            14: return 8'd229;
            15: return 8'd230;
            16: return 8'd231;
            default: return 8'd232;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] apply_mode(input acc_mode_e m,
                                                     input logic [BYTE_W-1:0] old,
                                                     input logic [BYTE_W-1:0] val);
        case (m)
            MODE_SETB:  return old | val;
            MODE_CLRB:  return old & ~val;
            MODE_WRITE: return val;
            default:    return old;
        endcase
    endfunction

    function automatic logic bw_ok(input logic [BYTE_W-1:0] v);
        return (v == 8'd0) || (v == 8'd1) || (v == 8'd2) || (v == 8'd5) || (v == 8'd6);
    endfunction

    function automatic logic cset_ok(input logic [CSET_W-1:0] c);
        return (c == 3'b001) || (c == 3'b010) || (c == 3'b100);
    endfunction

endpackage

// File: rtl/xcfg_decode.sv
module xcfg_decode
    import xcfg_pkg::*;
(
    input  logic                         req_en,
    input  logic [ARG_W-1:0]             arg,
    input  logic [N_WR-1:0][BYTE_W-1:0]  wr_q,
    output wr_cmd_t                      wr,
    output logic                         cset_we,
    output logic [CSET_W-1:0]            cset_new,
    output logic                         legal
);

    sw_arg_t           req;
    logic              hit;
    logic [SLOT_W-1:0] slot;
    logic              mbz_ok;
    logic [BYTE_W-1:0] new_byte;
    logic              is_cset;

    assign req = sw_arg_t'(arg);

    always_comb begin
        hit  = 1'b0;
        slot = '0;
        for (int s = 0; s < N_WR; s++) begin
            if (req.index == wr_index(s)) begin
                hit  = 1'b1;
                slot = SLOT_W'(s);
            end
        end
    end

    assign mbz_ok   = (req.mbz_hi == '0) && (req.mbz_lo == '0);
    assign is_cset  = (req.mode == MODE_CMDSET);
    assign new_byte = apply_mode(req.mode, wr_q[slot], req.value);

    always_comb begin
        if (is_cset) begin
            legal = mbz_ok && cset_ok(req.cset);
        end else begin
            legal = mbz_ok && hit && ((req.index != BW_IDX) || bw_ok(new_byte));
        end
    end

    assign wr.we    = req_en && legal && !is_cset;
    assign wr.slot  = slot;
    assign wr.data  = new_byte;
    assign cset_we  = req_en && legal && is_cset;
    assign cset_new = req.cset;

endmodule

// File: rtl/xcfg_store.sv
module xcfg_store
    import xcfg_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  wr_cmd_t                      wr,
    input  logic [RO_W-1:0]              ro_image,
    input  logic [IDX_W-1:0]             rd_idx,
    output logic [N_WR-1:0][BYTE_W-1:0]  wr_q,
    output logic [BYTE_W-1:0]            rd_data
);

    for (genvar g = 0; g < N_WR; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                wr_q[g] <= '0;
            end else if (wr.we && (wr.slot == SLOT_W'(g))) begin
                wr_q[g] <= wr.data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < N_RO; k++) begin
            if (rd_idx == ro_index(k)) begin
                rd_data = ro_image[k*BYTE_W +: BYTE_W];
            end
        end
        for (int s = 0; s < N_WR; s++) begin
            if (rd_idx == wr_index(s)) begin
                rd_data = wr_q[s];
            end
        end
    end

endmodule

// File: rtl/xcfg_busy.sv
module xcfg_busy #(
    parameter int unsigned BUSY_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);

    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYCLES);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= LOAD;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);

endmodule

// File: rtl/xcfg_switch_unit.sv
module xcfg_switch_unit
    import xcfg_pkg::*;
#(
    parameter int unsigned BUSY_CYCLES = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                arg_valid,
    input  logic [31:0]         arg,
    input  logic [143:0]        ro_image,
    input  logic [7:0]          rd_idx,
    output logic [7:0]          rd_data,
    output logic                busy,
    output logic                switch_err,
    output logic [2:0]          cmd_set
);

    logic                        take;
    logic                        legal;
    logic                        cset_we;
    logic [CSET_W-1:0]           cset_new;
    wr_cmd_t                     wr;
    logic [N_WR-1:0][BYTE_W-1:0] wr_q;

    assign take = arg_valid && !busy;

    xcfg_decode u_decode (
        .req_en   (take),
        .arg      (arg),
        .wr_q     (wr_q),
        .wr       (wr),
        .cset_we  (cset_we),
        .cset_new (cset_new),
        .legal    (legal)
    );

    xcfg_store u_store (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr),
        .ro_image (ro_image),
        .rd_idx   (rd_idx),
        .wr_q     (wr_q),
        .rd_data  (rd_data)
    );

    xcfg_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
        .clk   (clk),
        .rst   (rst),
        .start (take && legal),
        .busy  (busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_set    <= CSET_NORMAL;
            switch_err <= 1'b0;
        end else if (take) begin
            switch_err <= !legal;
            if (cset_we) begin
                cmd_set <= cset_new;
            end
        end
    end

endmodule

// File: rtl/xcfg_switch_chk.sv
module xcfg_switch_chk (
    input logic        clk,
    input logic        rst,
    input logic        arg_valid,
    input logic [31:0] arg,
    input logic        busy,
    input logic        switch_err,
    input logic [2:0]  cmd_set
);

    // R4: the command set always holds exactly one set bit
    a_r4_cset_onehot: assert property (@(posedge clk) disable iff (rst)
        $countones(cmd_set) == 1);

    // R7: any must-be-zero bit set gives a rejection
    a_r7_mbz_reject: assert property (@(posedge clk) disable iff (rst)
        (arg_valid && !busy && ((arg[31:26] != 6'd0) || (arg[7:3] != 5'd0)))
        |=> (switch_err && !busy));

    // R9: a taken request ends either busy (accepted) or in error (rejected)
    a_r9_take_outcome: assert property (@(posedge clk) disable iff (rst)
        (arg_valid && !busy) |=> (busy != switch_err));

    // R10: requests while busy leave the visible state alone
    a_r10_busy_ignore: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(cmd_set) && $stable(switch_err)));

endmodule

bind xcfg_switch_unit xcfg_switch_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .arg_valid  (arg_valid),
    .arg        (arg),
    .busy       (busy),
    .switch_err (switch_err),
    .cmd_set    (cmd_set)
);

// File: tb/xcfg_switch_unit_test.sv
module xcfg_switch_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int BUSY_N     = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic         arg_valid;
    logic [31:0]  arg;
    logic [143:0] ro_image;
    logic [7:0]   rd_idx;
    logic [7:0]   rd_data;
    logic         busy;
    logic         switch_err;
    logic [2:0]   cmd_set;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    logic [7:0] m_byte [256];
    logic [2:0] m_cset;
    logic       m_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    xcfg_switch_unit #(.BUSY_CYCLES(BUSY_N)) uut (
        .clk(clk), .rst(rst), .arg_valid(arg_valid), .arg(arg),
        .ro_image(ro_image), .rd_idx(rd_idx), .rd_data(rd_data),
        .busy(busy), .switch_err(switch_err), .cmd_set(cmd_set)
    );

    function automatic int wr_pos(input logic [7:0] i);
        case (i)
            8'd156: return 0;
            8'd175: return 1;
            8'd179: return 2;
            8'd183: return 3;
            8'd185: return 4;
            default: return -1;
        endcase
    endfunction

    function automatic logic [7:0] wr_at(input int k);
        case (k)
            0: return 8'd156; 1: return 8'd175; 2: return 8'd179;
            3: return 8'd183; default: return 8'd185;
        endcase
    endfunction

    function automatic logic [7:0] ro_at(input int k);
        if (k < 5) begin
            case (k)
                0: return 8'd160; 1: return 8'd166; 2: return 8'd192;
                3: return 8'd194; default: return 8'd196;
            endcase
        end
        if (k < 9)  return 8'(212 + k - 5);
        if (k == 9) return 8'd217;
        if (k < 14) return 8'(221 + k - 10);
        return 8'(229 + k - 14);
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] i);
        if (wr_pos(i) >= 0) return m_byte[i];
        for (int k = 0; k < 18; k++) if (ro_at(k) == i) return 8'hA0 + 8'(k);
        return 8'h00;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_read(input string req, input logic [7:0] i);
        rd_idx = i;
        #1;
        check(req, {24'd0, rd_data}, {24'd0, exp_read(i)});
    endtask

    // Issue one request, update the model, check the cycle after the take edge
    task automatic do_switch(input logic [31:0] a, input string req);
        logic [1:0] md;
        logic [7:0] idx, val, nv;
        logic       ok;
        md  = a[25:24];
        idx = a[23:16];
        val = a[15:8];
        ok  = (a[31:26] == 0) && (a[7:3] == 0);
        nv  = 8'h00;
        if (md == 2'd0) begin
            ok = ok && (a[2:0] == 3'b001 || a[2:0] == 3'b010 || a[2:0] == 3'b100);
        end else begin
            ok = ok && (wr_pos(idx) >= 0);
            if (wr_pos(idx) >= 0) begin
                nv = (md == 2'd1) ? (m_byte[idx] | val) :
                     (md == 2'd2) ? (m_byte[idx] & ~val) : val;
                if (idx == 8'd183)
                    ok = ok && (nv == 0 || nv == 1 || nv == 2 || nv == 5 || nv == 6);
            end
        end
        @(negedge clk);
        arg = a; arg_valid = 1'b1;
        @(negedge clk);
        arg_valid = 1'b0;
        m_err = !ok;
        if (ok && md == 2'd0) m_cset = a[2:0];
        if (ok && md != 2'd0) m_byte[idx] = nv;
        check({req, " R9 err"}, {31'd0, switch_err}, {31'd0, m_err});
        check({req, " R4 cset"}, {29'd0, cmd_set}, {29'd0, m_cset});
        check_read({req, " byte"}, idx);
        check({req, " R9 busy rise"}, {31'd0, busy}, {31'd0, ok});
        if (ok) begin
            repeat (BUSY_N - 1) @(negedge clk);
            check({req, " R9 busy hold"}, {31'd0, busy}, 32'd1);
            @(negedge clk);
            check({req, " R9 busy end"}, {31'd0, busy}, 32'd0);
        end
    endtask

    function automatic logic [31:0] mk(input logic [1:0] md, input logic [7:0] i,
                                       input logic [7:0] v, input logic [2:0] cs);
        return {6'd0, md, i, v, 5'd0, cs};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < 18; k++) ro_image[k*8 +: 8] = 8'hA0 + 8'(k);
        for (int i = 0; i < 256; i++) m_byte[i] = 8'h00;
        m_cset = 3'b001; m_err = 1'b0;
        rst = 1'b1; arg_valid = 1'b0; arg = '0; rd_idx = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Reset state
        check("R4 reset cset", {29'd0, cmd_set}, 32'd1);
        check("R9 reset busy", {31'd0, busy}, 32'd0);
        check("R9 reset err", {31'd0, switch_err}, 32'd0);
        for (int k = 0; k < 5; k++) check_read("R5 reset byte", wr_at(k));
        for (int k = 0; k < 18; k++) check_read("R6 R11 ro byte", ro_at(k));
        check_read("R6 unimplemented", 8'd0);
        check_read("R6 unimplemented", 8'd255);

        // Directed
        do_switch(mk(2'd3, 8'd156, 8'h5A, 3'd0), "R1 write");
        do_switch(mk(2'd1, 8'd156, 8'h81, 3'd0), "R2 set");
        do_switch(mk(2'd2, 8'd156, 8'h18, 3'd0), "R3 clear");
        do_switch(mk(2'd3, 8'd183, 8'd6, 3'd0), "R8 bw ok");
        do_switch(mk(2'd3, 8'd183, 8'd3, 3'd0), "R8 bw reject");
        do_switch(mk(2'd1, 8'd183, 8'd1, 3'd0), "R8 bw set to 7");
        do_switch(mk(2'd3, 8'd192, 8'hFF, 3'd0), "R6 ro write");
        do_switch(mk(2'd3, 8'd10, 8'hFF, 3'd0), "R6 unimpl write");
        do_switch(mk(2'd0, 8'd0, 8'd0, 3'b010), "R4 cset secure");
        do_switch(mk(2'd0, 8'd0, 8'd0, 3'b011), "R4 cset bad");
        do_switch(mk(2'd0, 8'd0, 8'd0, 3'b000), "R4 cset zero");
        do_switch(mk(2'd3, 8'd175, 8'h33, 3'd0) | 32'h0400_0000, "R7 mbz hi");
        do_switch(mk(2'd3, 8'd175, 8'h33, 3'd0) | 32'h0000_0080, "R7 mbz lo");
        do_switch(mk(2'd0, 8'd0, 8'd0, 3'b001) | 32'h0000_0008, "R7 mbz cset");
        do_switch(mk(2'd3, 8'd185, 8'hC3, 3'd0), "R1 write 185");
        do_switch(mk(2'd3, 8'd179, 8'h0F, 3'd0), "R5 write 179");

        // R10: request during busy is dropped
        @(negedge clk);
        arg = mk(2'd3, 8'd175, 8'h11, 3'd0); arg_valid = 1'b1;
        @(negedge clk);
        arg = mk(2'd3, 8'd175, 8'h22, 3'd0);
        m_byte[175] = 8'h11;
        @(negedge clk);
        arg = mk(2'd0, 8'd0, 8'd0, 3'b100);
        @(negedge clk);
        arg_valid = 1'b0;
        check("R10 err unchanged", {31'd0, switch_err}, 32'd0);
        check("R10 cset unchanged", {29'd0, cmd_set}, {29'd0, m_cset});
        check_read("R10 byte unchanged", 8'd175);
        repeat (BUSY_N + 1) @(negedge clk);
        check("R10 busy over", {31'd0, busy}, 32'd0);
        check_read("R10 byte after", 8'd175);
        m_err = 1'b0;

        // Random
        for (int n = 0; n < 300; n++) begin
            logic [7:0]  i;
            logic [7:0]  v;
            logic [1:0]  md;
            logic [31:0] a;
            case ($urandom % 4)
                0: i = wr_at(int'($urandom % 5));
                1: i = ro_at(int'($urandom % 18));
                2: i = 8'($urandom);
                default: i = 8'd183;
            endcase
            md = 2'($urandom);
            v  = ($urandom % 2 == 0) ? 8'($urandom % 8) : 8'($urandom);
            a  = mk(md, i, v, 3'($urandom));
            if ($urandom % 8 == 0) a = a | (32'd1 << (($urandom % 2 == 0) ? (26 + $urandom % 6) : (3 + $urandom % 5)));
            do_switch(a, "R1 R2 R3 R4 R6 R7 R8 random");
        end

        for (int k = 0; k < 5; k++) check_read("R5 final byte", wr_at(k));

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule